// File: doc/BRIEF.md
# Host Keyboard to Key-Matrix Translator

This block stands between a host keyboard receiver and a CPU that expects an 8-by-5 switch matrix. The receiver hands it one decoded event per clock: an 8-bit scan code (set-2 make code) and a flag that says whether the key went down or came up. The block keeps a held/not-held bit for each of the 40 matrix positions. It also records the state of the host shift and alt keys, and which multi-key shortcut keys are being held.

When the CPU reads the keyboard port, the high address byte selects the half-rows. The block answers at once, combinationally, with an active-low byte. Host keys that have no matrix position of their own, such as backspace or punctuation, are turned into a base key pressed together with one of the two machine shift keys. A mode input lets a four-direction gamepad with a fire button stand in for one of the two numeric half-rows.

Matrix layout. Half-row r is read on address bit A(8+r) and on data bits D0..D4. The rows are:
- r0: CAPS, Z, X, C, V
- r1: A, S, D, F, G
- r2: Q, W, E, R, T
- r3: 1, 2, 3, 4, 5
- r4: 0, 9, 8, 7, 6
- r5: P, O, I, U, Y
- r6: ENTER, L, K, J, H
- r7: SPACE, SYM, M, N, B

Top module: `kbm_matrix_xlate`

## Requirements
- R1: After a synchronous reset every matrix key reads as released. With the joystick mode off, `key_data` is 0xFF for any address.
- R2: Address bit A(8+r) low selects half-row r, using the layout above. The columns of a selected row drive D0..D4. Rows that are not selected contribute nothing.
- R3: Data is active-low: a held key reads 0. `key_data[7:5]` is always 1. When no address bit is low, D0..D4 read all ones.
- R4: When several address bits are low at once, D0..D4 are the bitwise AND of every selected half-row.
- R5: A press event sets a key and a release event (`ev_release`=1) clears it. The change becomes visible on the read after the clock edge that took the event. Letters and digits use set-2 codes, for example A=0x1C, Z=0x1A, 1=0x16, and unknown codes are ignored.
- R6: An event whose code maps to nothing leaves every read unchanged. An example is 0x77. A release of a key that is not held also changes nothing.
- R7: Either host shift (0x12 or 0x59) holds CAPS while at least one of them is down. Host alt (0x11) holds SYM.
- R8: Shortcut keys press a machine shift and a base key together. The mappings are:
  - backspace 0x66 gives CAPS+0
  - caps-lock 0x58 gives CAPS+2
  - comma 0x41 gives SYM+N
  - period 0x49 gives SYM+M
  - minus 0x4E gives SYM+J
  - equals 0x55 gives SYM+L
- R9: While a shortcut that uses SYM is held, CAPS coming from host shift is masked.
- R10: Equals pressed while host shift is down gives SYM+K instead of SYM+L. The choice is made at press time and does not change until release.
- R11: Releasing a shortcut removes only its own synthesised keys. A machine shift that a host shift or alt key still holds stays pressed.
- R12: With `joy_en`=1 the gamepad buttons `joy_btn`={fire,up,down,right,left} (active-high) press keys in one half-row. With `joy_sel`=0 they press 5,4,3,2,1. With `joy_sel`=1 they press 0,9,8,7,6. With `joy_en`=0 the buttons have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid | input | 1 | A key event is present this cycle |
| ev_release | input | 1 | 1 = key released, 0 = key pressed |
| ev_code | input | 8 | Set-2 make code of the key |
| addr_hi | input | 8 | Upper CPU address byte (half-row select, active-low) |
| joy_en | input | 1 | Gamepad-as-numeric-keys mode enable |
| joy_sel | input | 1 | 0 = row of 1-5, 1 = row of 6-0 |
| joy_btn | input | 5 | {fire, up, down, right, left}, active-high |
| key_data | output | 8 | Port read data, active-low keys in bits 4:0 |

## Verification
The bench reads several half-rows at once and compares the result with the AND of the rows. A design that ORs the rows, or that reads only the lowest selected row, returns the wrong pattern. It holds host shift while a SYM shortcut is down and then releases keys in overlapping orders. A design that does not mask CAPS, or that clears a physically held shift when the shortcut lets go, shows a wrong bit 0 on row 0 or bit 1 on row 7. It releases shift before equals to catch a variant that is recomputed live rather than latched. It drives gamepad buttons into both numeric rows to expose a mirrored column order and a mode gate that does not work.

// File: rtl/kbm_pkg.sv
package kbm_pkg;

    localparam int KB_ROWS  = 8;
    localparam int KB_COLS  = 5;
    localparam int KB_KEYS  = KB_ROWS * KB_COLS;
    localparam int IDX_W    = $clog2(KB_KEYS);
    localparam int CODE_W   = 8;
    localparam int N_SC     = 6;
    localparam int SC_W     = $clog2(N_SC);
    localparam int JOY_W    = 5;
    localparam int ADDR_W   = 8;
    localparam int DATA_W   = 8;

    // Fixed matrix positions of the two machine shift keys
    localparam int KEY_CAPS = 0;
    localparam int KEY_SYM  = 7 * KB_COLS + 1;

    typedef enum logic [2:0] {
        EV_NONE,
        EV_MATRIX,
        EV_LSHIFT,
        EV_RSHIFT,
        EV_ALT,
        EV_SHORTCUT
    } ev_kind_e;

    typedef enum logic [SC_W-1:0] {
        SC_BKSP   = 3'd0,
        SC_CAPSLK = 3'd1,
        SC_COMMA  = 3'd2,
        SC_PERIOD = 3'd3,
        SC_MINUS  = 3'd4,
        SC_EQUALS = 3'd5
    } shortcut_e;

    typedef struct packed {
        ev_kind_e           kind;
        logic [IDX_W-1:0]   key;
        shortcut_e          sc;
        logic               rel;
    } ev_cmd_t;

    function automatic logic [IDX_W-1:0] kpos(input int row, input int col);
        return IDX_W'(row * KB_COLS + col);
    endfunction

    // Classify a set-2 make code
    function automatic ev_cmd_t classify(input logic [CODE_W-1:0] c, input logic rel);
        ev_cmd_t e;
        e.kind = EV_MATRIX;
        e.key  = '0;
        e.sc   = SC_BKSP;
        e.rel  = rel;
        case (c)
            8'h1A: e.key = kpos(0, 1);
            8'h22: e.key = kpos(0, 2);
            8'h21: e.key = kpos(0, 3);
            8'h2A: e.key = kpos(0, 4);
            8'h1C: e.key = kpos(1, 0);
            8'h1B: e.key = kpos(1, 1);
            8'h23: e.key = kpos(1, 2);
            8'h2B: e.key = kpos(1, 3);
            8'h34: e.key = kpos(1, 4);
            8'h15: e.key = kpos(2, 0);
            8'h1D: e.key = kpos(2, 1);
            8'h24: e.key = kpos(2, 2);
            8'h2D: e.key = kpos(2, 3);
            8'h2C: e.key = kpos(2, 4);
            8'h16: e.key = kpos(3, 0);
            8'h1E: e.key = kpos(3, 1);
            8'h26: e.key = kpos(3, 2);
            8'h25: e.key = kpos(3, 3);
            8'h2E: e.key = kpos(3, 4);
            8'h45: e.key = kpos(4, 0);
            8'h46: e.key = kpos(4, 1);
            8'h3E: e.key = kpos(4, 2);
            8'h3D: e.key = kpos(4, 3);
            8'h36: e.key = kpos(4, 4);
            8'h4D: e.key = kpos(5, 0);
            8'h44: e.key = kpos(5, 1);
            8'h43: e.key = kpos(5, 2);
            8'h3C: e.key = kpos(5, 3);
            8'h35: e.key = kpos(5, 4);
            8'h5A: e.key = kpos(6, 0);
            8'h4B: e.key = kpos(6, 1);
            8'h42: e.key = kpos(6, 2);
            8'h3B: e.key = kpos(6, 3);
            8'h33: e.key = kpos(6, 4);
            8'h29: e.key = kpos(7, 0);
            8'h3A: e.key = kpos(7, 2);
            8'h31: e.key = kpos(7, 3);
            8'h32: e.key = kpos(7, 4);
            8'h12: e.kind = EV_LSHIFT;
            8'h59: e.kind = EV_RSHIFT;
            8'h11: e.kind = EV_ALT;
            8'h66: begin e.kind = EV_SHORTCUT; e.sc = SC_BKSP;   end
            8'h58: begin e.kind = EV_SHORTCUT; e.sc = SC_CAPSLK; end
            8'h41: begin e.kind = EV_SHORTCUT; e.sc = SC_COMMA;  end
            8'h49: begin e.kind = EV_SHORTCUT; e.sc = SC_PERIOD; end
            8'h4E: begin e.kind = EV_SHORTCUT; e.sc = SC_MINUS;  end
            8'h55: begin e.kind = EV_SHORTCUT; e.sc = SC_EQUALS; end
            default: e.kind = EV_NONE;
        endcase
        return e;
    endfunction

    // Base key of a shortcut; variant selects the shifted form
    function automatic logic [IDX_W-1:0] sc_base(input int i, input logic variant);
        case (i)
            0:       return kpos(4, 0);
            1:       return kpos(3, 1);
            2:       return kpos(7, 3);
            3:       return kpos(7, 2);
            4:       return kpos(6, 3);
            default: return variant ? kpos(6, 2) : kpos(6, 1);
        endcase
    endfunction

    function automatic logic sc_uses_sym(input int i);
        return (i >= 2);
    endfunction

    // Gamepad button b ({fire,up,down,right,left} = 4..0) to matrix key
    function automatic logic [IDX_W-1:0] joy_key(input logic sel, input int b);
        return sel ? kpos(4, (JOY_W - 1) - b) : kpos(3, b);
    endfunction

endpackage

// File: rtl/kbm_event_decode.sv
module kbm_event_decode
    import kbm_pkg::*;
(
    input  logic                ev_valid,
    input  logic                ev_release,
    input  logic [CODE_W-1:0]   ev_code,
    output ev_cmd_t             cmd
);
    ev_cmd_t raw;

    always_comb begin
        raw = classify(ev_code, ev_release);
        cmd = raw;
        if (!ev_valid) cmd.kind = EV_NONE;
    end
endmodule

// File: rtl/kbm_key_state.sv
module kbm_key_state
    import kbm_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  ev_cmd_t             cmd,
    output logic [KB_KEYS-1:0]  direct,
    output logic                host_shift,
    output logic                host_alt,
    output logic [N_SC-1:0]     sc_held,
    output logic                eq_variant
);
    logic lsh_q, rsh_q, alt_q, eqv_q;
    logic [KB_KEYS-1:0] dir_q;
    logic [N_SC-1:0]    sc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q <= '0;
            sc_q  <= '0;
            lsh_q <= 1'b0;
            rsh_q <= 1'b0;
            alt_q <= 1'b0;
            eqv_q <= 1'b0;
        end else begin
            case (cmd.kind)
                EV_MATRIX: dir_q[cmd.key] <= !cmd.rel;
                EV_LSHIFT: lsh_q <= !cmd.rel;
                EV_RSHIFT: rsh_q <= !cmd.rel;
                EV_ALT:    alt_q <= !cmd.rel;
                EV_SHORTCUT: begin
                    sc_q[cmd.sc] <= !cmd.rel;
                    if (cmd.sc == SC_EQUALS && !cmd.rel)
                        eqv_q <= lsh_q | rsh_q;
                end
                default: ;
            endcase
        end
    end

    assign direct     = dir_q;
    assign host_shift = lsh_q | rsh_q;
    assign host_alt   = alt_q;
    assign sc_held    = sc_q;
    assign eq_variant = eqv_q;
endmodule

// File: rtl/kbm_compose.sv
module kbm_compose
    import kbm_pkg::*;
(
    input  logic [KB_KEYS-1:0]  direct,
    input  logic                host_shift,
    input  logic                host_alt,
    input  logic [N_SC-1:0]     sc_held,
    input  logic                eq_variant,
    input  logic                joy_en,
    input  logic                joy_sel,
    input  logic [JOY_W-1:0]    joy_btn,
    output logic [KB_KEYS-1:0]  pressed
);
    logic [KB_KEYS-1:0] sc_vec  [N_SC];
    logic [KB_KEYS-1:0] joy_vec [JOY_W];
    logic [N_SC-1:0]    sym_sc;

    for (genvar i = 0; i < N_SC; i++) begin : g_sc
        always_comb begin
            sc_vec[i] = '0;
            if (sc_held[i]) begin
                sc_vec[i][sc_base(i, eq_variant)] = 1'b1;
                if (sc_uses_sym(i)) sc_vec[i][KEY_SYM]  = 1'b1;
                else                sc_vec[i][KEY_CAPS] = 1'b1;
            end
        end
        assign sym_sc[i] = sc_held[i] & sc_uses_sym(i);
    end

    for (genvar b = 0; b < JOY_W; b++) begin : g_joy
        always_comb begin
            joy_vec[b] = '0;
            if (joy_en && joy_btn[b]) joy_vec[b][joy_key(joy_sel, b)] = 1'b1;
        end
    end

    always_comb begin
        pressed = direct;
        for (int i = 0; i < N_SC; i++)  pressed |= sc_vec[i];
        for (int b = 0; b < JOY_W; b++) pressed |= joy_vec[b];
        if (host_shift && !(|sym_sc)) pressed[KEY_CAPS] = 1'b1;
        if (host_alt)                 pressed[KEY_SYM]  = 1'b1;
    end
endmodule

// File: rtl/kbm_row_read.sv
module kbm_row_read
    import kbm_pkg::*;
(
    input  logic [KB_KEYS-1:0]  pressed,
    input  logic [ADDR_W-1:0]   addr_hi,
    output logic [DATA_W-1:0]   data
);
    logic [KB_COLS-1:0] acc;

    always_comb begin
        acc = '1;
        for (int r = 0; r < KB_ROWS; r++)
            if (!addr_hi[r]) acc &= ~pressed[r*KB_COLS +: KB_COLS];
        data = {{(DATA_W-KB_COLS){1'b1}}, acc};
    end
endmodule

// File: rtl/kbm_matrix_xlate.sv
module kbm_matrix_xlate
    import kbm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ev_valid,
    input  logic              ev_release,
    input  logic [7:0]        ev_code,
    input  logic [7:0]        addr_hi,
    input  logic              joy_en,
    input  logic              joy_sel,
    input  logic [4:0]        joy_btn,
    output logic [7:0]        key_data
);
    ev_cmd_t            cmd;
    logic [KB_KEYS-1:0] direct, pressed;
    logic               host_shift, host_alt, eq_variant;
    logic [N_SC-1:0]    sc_held;

    kbm_event_decode u_dec (
        .ev_valid   (ev_valid),
        .ev_release (ev_release),
        .ev_code    (ev_code),
        .cmd        (cmd)
    );

    kbm_key_state u_state (
        .clk        (clk),
        .rst        (rst),
        .cmd        (cmd),
        .direct     (direct),
        .host_shift (host_shift),
        .host_alt   (host_alt),
        .sc_held    (sc_held),
        .eq_variant (eq_variant)
    );

    kbm_compose u_comp (
        .direct     (direct),
        .host_shift (host_shift),
        .host_alt   (host_alt),
        .sc_held    (sc_held),
        .eq_variant (eq_variant),
        .joy_en     (joy_en),
        .joy_sel    (joy_sel),
        .joy_btn    (joy_btn),
        .pressed    (pressed)
    );

    kbm_row_read u_read (
        .pressed (pressed),
        .addr_hi (addr_hi),
        .data    (key_data)
    );
endmodule

// File: rtl/kbm_matrix_chk.sv
module kbm_matrix_chk (
    input logic       clk,
    input logic       rst,
    input logic       ev_valid,
    input logic [7:0] addr_hi,
    input logic       joy_en,
    input logic       joy_sel,
    input logic [4:0] joy_btn,
    input logic [7:0] key_data
);
    // R3
    upper_bits_high_chk: assert property (@(posedge clk) disable iff (rst)
        key_data[7:5] == 3'b111);

    // R3
    no_row_selected_chk: assert property (@(posedge clk) disable iff (rst)
        (addr_hi == 8'hFF) |-> (key_data[4:0] == 5'h1F));

    // R1
    reset_release_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && !joy_en) |-> (key_data == 8'hFF));

    // R6
    hold_without_event_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(ev_valid) && $stable(addr_hi) && $stable(joy_en)
         && $stable(joy_sel) && $stable(joy_btn)) |-> $stable(key_data));

    // R12
    joy_fire_low_row_chk: assert property (@(posedge clk) disable iff (rst)
        (joy_en && joy_btn[4] && !joy_sel && !addr_hi[3]) |-> !key_data[4]);

    // R12
    joy_fire_high_row_chk: assert property (@(posedge clk) disable iff (rst)
        (joy_en && joy_btn[4] && joy_sel && !addr_hi[4]) |-> !key_data[0]);
endmodule

bind kbm_matrix_xlate kbm_matrix_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .ev_valid (ev_valid),
    .addr_hi  (addr_hi),
    .joy_en   (joy_en),
    .joy_sel  (joy_sel),
    .joy_btn  (joy_btn),
    .key_data (key_data)
);

// File: tb/sim_kbm_matrix_xlate.sv
module sim_kbm_matrix_xlate;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ev_valid = 1'b0;
    logic       ev_release = 1'b0;
    logic [7:0] ev_code = 8'h00;
    logic [7:0] addr_hi = 8'hFF;
    logic       joy_en = 1'b0;
    logic       joy_sel = 1'b0;
    logic [4:0] joy_btn = 5'b0;
    logic [7:0] key_data;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    kbm_matrix_xlate u0 (
        .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_release(ev_release),
        .ev_code(ev_code), .addr_hi(addr_hi), .joy_en(joy_en),
        .joy_sel(joy_sel), .joy_btn(joy_btn), .key_data(key_data)
    );

    task automatic key(input logic [7:0] code, input logic rel);
        @(negedge clk);
        ev_valid = 1'b1; ev_code = code; ev_release = rel;
        @(negedge clk);
        ev_valid = 1'b0;
    endtask

    task automatic rd(input string req, input logic [7:0] a, input logic [7:0] exp);
        addr_hi = a;
        #1;
        checks++;
        if (key_data !== exp) begin
            errors++;
            $display("FAIL %s addr=%h actual=%h expected=%h", req, a, key_data, exp);
        end
    endtask

    task automatic t_reset;
        rd("R1", 8'h00, 8'hFF);
        rd("R1", 8'hFE, 8'hFF);
        rd("R3", 8'hFF, 8'hFF);
    endtask

    task automatic t_single;
        key(8'h1C, 1'b0);               // A: row1 col0
        rd("R2", 8'hFD, 8'hFE);
        rd("R2", 8'hFE, 8'hFF);
        key(8'h1C, 1'b1);
        rd("R5", 8'hFD, 8'hFF);
    endtask

    task automatic t_multi;
        key(8'h1A, 1'b0);               // Z: row0 col1
        key(8'h16, 1'b0);               // 1: row3 col0
        rd("R4", 8'hF6, 8'hFC);
        rd("R2", 8'hFE, 8'hFD);
        rd("R2", 8'hF7, 8'hFE);
        key(8'h1A, 1'b1);
        key(8'h16, 1'b1);
        rd("R5", 8'h00, 8'hFF);
    endtask

    task automatic t_ignore;
        key(8'h77, 1'b0);
        rd("R6", 8'h00, 8'hFF);
        key(8'h24, 1'b1);               // release of E never pressed
        rd("R6", 8'h00, 8'hFF);
    endtask

    task automatic t_shift;
        key(8'h12, 1'b0);
        rd("R7", 8'hFE, 8'hFE);
        key(8'h59, 1'b0);
        key(8'h12, 1'b1);
        rd("R7", 8'hFE, 8'hFE);
        key(8'h59, 1'b1);
        rd("R7", 8'hFE, 8'hFF);
        key(8'h11, 1'b0);
        rd("R7", 8'h7F, 8'hFD);
        key(8'h11, 1'b1);
        rd("R7", 8'h7F, 8'hFF);
    endtask

    task automatic t_shortcut;
        key(8'h66, 1'b0);               // CAPS + 0
        rd("R8", 8'hFE, 8'hFE);
        rd("R8", 8'hEF, 8'hFE);
        rd("R8", 8'hEE, 8'hFE);
        key(8'h66, 1'b1);
        rd("R8", 8'h00, 8'hFF);
        key(8'h49, 1'b0);               // SYM + M
        rd("R8", 8'h7F, 8'hF9);
        key(8'h49, 1'b1);
    endtask

    task automatic t_sym_mask;
        key(8'h12, 1'b0);
        key(8'h41, 1'b0);               // SYM + N
        rd("R9", 8'hFE, 8'hFF);
        rd("R8", 8'h7F, 8'hF5);
        key(8'h41, 1'b1);
        rd("R11", 8'hFE, 8'hFE);
        rd("R11", 8'h7F, 8'hFF);
        key(8'h12, 1'b1);
        key(8'h11, 1'b0);
        key(8'h41, 1'b0);
        rd("R11", 8'h7F, 8'hF5);
        key(8'h41, 1'b1);
        rd("R11", 8'h7F, 8'hFD);
        key(8'h11, 1'b1);
        rd("R11", 8'h00, 8'hFF);
    endtask

    task automatic t_equals;
        key(8'h55, 1'b0);
        rd("R10", 8'hBF, 8'hFD);
        key(8'h55, 1'b1);
        key(8'h12, 1'b0);
        key(8'h55, 1'b0);
        rd("R10", 8'hBF, 8'hFB);
        key(8'h12, 1'b1);
        rd("R10", 8'hBF, 8'hFB);
        key(8'h55, 1'b1);
        rd("R10", 8'h00, 8'hFF);
    endtask

    task automatic t_joy;
        @(negedge clk);
        joy_btn = 5'b11111; joy_en = 1'b0;
        rd("R12", 8'h00, 8'hFF);
        joy_en = 1'b1; joy_sel = 1'b0; joy_btn = 5'b10000;
        rd("R12", 8'hF7, 8'hEF);
        joy_btn = 5'b00001;
        rd("R12", 8'hF7, 8'hFE);
        joy_sel = 1'b1; joy_btn = 5'b10000;
        rd("R12", 8'hEF, 8'hFE);
        joy_btn = 5'b00001;
        rd("R12", 8'hEF, 8'hEF);
        rd("R12", 8'hF7, 8'hFF);
        joy_en = 1'b0; joy_btn = 5'b0;
    endtask

    task automatic finish_run;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_single();
        t_multi();
        t_ignore();
        t_shift();
        t_shortcut();
        t_sym_mask();
        t_equals();
        t_joy();
        finish_run();
    end

    initial begin
        #(CLK_PERIOD * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end
endmodule